// File: doc/BRIEF.md
# Parallel-Carry Radix Vector Adder

This block adds two vectors of digits lane by lane in a number base that is chosen at run time. Each lane holds one digit of `DIGIT_W` bits, and lane 0 is the least significant digit. Every digit of both operands must be below the radix; any other digit value gives an unspecified result. The carry does not pass from lane to lane through the logic. Each lane reports two flags: a *generate* flag when its own digit sum already reaches the radix, and a *propagate* flag when that sum is exactly one below the radix. The flags of all lanes are packed into two words. A single binary addition followed by an XOR then gives the carry entering every lane, so the whole digit vector settles in one pass.

The block is used as a multi-digit adder in decimal, binary or any other base up to 2^`DIGIT_W`, for example in a bignum or BCD-like datapath. The caller presents both operands, the radix and an incoming carry together with a valid strobe. The registered result appears on the following cycle, with an outgoing carry, a flag that says no lane received a carry, and an error flag for an unusable radix.

Top module: `radix_carry_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. While `in_valid` is low, every result output keeps its previous value, whatever the data inputs do.
- R2: Result lane i occupies bits [i*DIGIT_W +: DIGIT_W] of `sum_digits`, like the operands. Its value is (A_i + B_i + carry into lane i) mod radix.
- R3: Lane 0 takes `carry_in` as its incoming carry. Lane i > 0 takes a carry exactly when A_(i-1) + B_(i-1) + carry into lane i-1 is at least the radix.
- R4: A carry crosses any run of lanes whose digit sums equal radix-1, including all lanes at once, within the same single cycle of latency.
- R5: `carry_out` is the carry leaving the most significant lane.
- R6: `no_prop` is 1 exactly when no lane, lane 0 included, receives an incoming carry.
- R7: A radix below 2 or above 2^DIGIT_W sets `radix_err` to 1 and forces `sum_digits`, `carry_out` and `no_prop` to 0. A usable radix clears `radix_err`.
- R8: A radix of exactly 2^DIGIT_W is accepted and behaves as plain binary addition of full-width digits.
- R9: During reset and until the first valid input, `out_valid`, `sum_digits`, `carry_out`, `no_prop` and `radix_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously inside the block |
| in_valid | input | 1 | Operands are valid and are captured this cycle |
| a_digits | input | LANES*DIGIT_W | First operand, lane 0 in the low bits |
| b_digits | input | LANES*DIGIT_W | Second operand, lane 0 in the low bits |
| radix | input | DIGIT_W+1 | Number base, usable range 2 to 2^DIGIT_W |
| carry_in | input | 1 | Carry into lane 0 |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| sum_digits | output | LANES*DIGIT_W | Result digits |
| carry_out | output | 1 | Carry leaving the top lane |
| no_prop | output | 1 | No lane received an incoming carry |
| radix_err | output | 1 | The radix was outside the usable range |

## Verification
The bench targets the following cases and how a faulty design would show them:
- **Full-length carry chains.** Every lane holds radix-1 and `carry_in` is set. A design with broken carry resolution would leave one or more high lanes at radix-1 instead of zero, or drop `carry_out`.
- **Radix edges.** The bench uses radix 2, 2^DIGIT_W and the rejected values either side. An off-by-one in the range check would either corrupt binary-width sums or let a bad radix through without zeroing the outputs.
- **No-propagation flag.** The bench toggles `carry_in` on operands that otherwise never carry. A design that derived the flag without lane 0's carry would report no propagation when one occurred.
- **Idle cycles.** Junk data arrives with the strobe low. A design that ignored the enable would overwrite the held result.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  // Per-lane carry-lookahead flags.
  typedef struct packed {
    logic gen;   // lane sum alone reaches the radix
    logic prop;  // lane sum is exactly one below the radix
  } pg_t;

  // A radix is usable when it is at least 2 and fits a digit of dw bits.
  function automatic logic radix_in_range(input logic [31:0] r, input int unsigned dw);
    return (r >= 32'd2) && (r <= (32'd1 << dw));
  endfunction

endpackage

// File: rtl/rcp_lane_prep.sv
module rcp_lane_prep #(
  parameter int DIGIT_W = 8
) (
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  logic [DIGIT_W:0]   radix,
  output logic [DIGIT_W:0]   lane_sum,
  output rcp_pkg::pg_t       flags
);
  localparam int RW = DIGIT_W + 1;

  logic [RW:0] sum_plus_one;

  always_comb begin
    lane_sum     = {1'b0, a_dig} + {1'b0, b_dig};
    sum_plus_one = {1'b0, lane_sum} + {{RW{1'b0}}, 1'b1};
    flags.gen    = (lane_sum >= radix);
    flags.prop   = (sum_plus_one == {1'b0, radix});
  end

endmodule

// File: rtl/rcp_carry_net.sv
module rcp_carry_net #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] gen_vec,
  input  logic [LANES-1:0] prop_vec,
  input  logic             carry_in,
  output logic [LANES-1:0] lane_carry,
  output logic             carry_out
);
  localparam int SW = LANES + 1;

  logic [SW-1:0] chain_sum;

  // One wide add lets every generate ripple through all propagate runs,
  // the incoming carry entering as the low-order addend.
  always_comb begin
    chain_sum  = {1'b0, prop_vec | gen_vec} + {1'b0, gen_vec} + {{LANES{1'b0}}, carry_in};
    lane_carry = chain_sum[LANES-1:0] ^ prop_vec;
    carry_out  = chain_sum[LANES];
  end

endmodule

// File: rtl/rcp_lane_fix.sv
module rcp_lane_fix #(
  parameter int DIGIT_W = 8
) (
  input  logic [DIGIT_W:0]   lane_sum,
  input  logic               carry,
  input  logic [DIGIT_W:0]   radix,
  output logic [DIGIT_W-1:0] digit
);
  localparam int RW = DIGIT_W + 1;

  logic [RW-1:0] total;
  logic [RW-1:0] wrapped;

  always_comb begin
    total   = lane_sum + {{(RW-1){1'b0}}, carry};
    wrapped = total - radix;
    digit   = (total >= radix) ? wrapped[DIGIT_W-1:0] : total[DIGIT_W-1:0];
  end

endmodule

// File: rtl/radix_carry_unit.sv
module radix_carry_unit #(
  parameter int LANES   = 8,
  parameter int DIGIT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANES*DIGIT_W-1:0] a_digits,
  input  logic [LANES*DIGIT_W-1:0] b_digits,
  input  logic [DIGIT_W:0]         radix,
  input  logic                     carry_in,
  output logic                     out_valid,
  output logic [LANES*DIGIT_W-1:0] sum_digits,
  output logic                     carry_out,
  output logic                     no_prop,
  output logic                     radix_err
);
  localparam int RW = DIGIT_W + 1;
  localparam int VW = LANES * DIGIT_W;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Lane flags and local sums.
  logic [LANES-1:0] gen_vec;
  logic [LANES-1:0] prop_vec;
  logic [LANES-1:0] lane_carry;
  logic [RW-1:0]    lane_sum [LANES];
  logic [VW-1:0]    digits_calc;
  logic             cout_calc;
  logic             radix_bad;

  assign radix_bad = !rcp_pkg::radix_in_range(32'(radix), DIGIT_W);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rcp_pkg::pg_t flags;

    rcp_lane_prep #(.DIGIT_W(DIGIT_W)) u_prep (
      .a_dig    (a_digits[i*DIGIT_W +: DIGIT_W]),
      .b_dig    (b_digits[i*DIGIT_W +: DIGIT_W]),
      .radix    (radix),
      .lane_sum (lane_sum[i]),
      .flags    (flags)
    );

    assign gen_vec[i]  = flags.gen;
    assign prop_vec[i] = flags.prop;

    rcp_lane_fix #(.DIGIT_W(DIGIT_W)) u_fix (
      .lane_sum (lane_sum[i]),
      .carry    (lane_carry[i]),
      .radix    (radix),
      .digit    (digits_calc[i*DIGIT_W +: DIGIT_W])
    );
  end

  rcp_carry_net #(.LANES(LANES)) u_net (
    .gen_vec    (gen_vec),
    .prop_vec   (prop_vec),
    .carry_in   (carry_in),
    .lane_carry (lane_carry),
    .carry_out  (cout_calc)
  );

  // Next-state.
  logic [VW-1:0] digits_nxt;
  logic          cout_nxt;
  logic          noprop_nxt;
  logic          err_nxt;

  always_comb begin
    if (radix_bad) begin
      digits_nxt = '0;
      cout_nxt   = 1'b0;
      noprop_nxt = 1'b0;
      err_nxt    = 1'b1;
    end else begin
      digits_nxt = digits_calc;
      cout_nxt   = cout_calc;
      noprop_nxt = ~|lane_carry;
      err_nxt    = 1'b0;
    end
  end

  // Registers, loaded only under the input strobe.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid  <= 1'b0;
      sum_digits <= '0;
      carry_out  <= 1'b0;
      no_prop    <= 1'b0;
      radix_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum_digits <= digits_nxt;
        carry_out  <= cout_nxt;
        no_prop    <= noprop_nxt;
        radix_err  <= err_nxt;
      end
    end
  end

  // Assertions.
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(sum_digits) && $stable(carry_out)
                   && $stable(no_prop) && $stable(radix_err)));

  a_r7_bad_radix_zeroes: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && radix_bad) |=> (radix_err && sum_digits == '0 && !carry_out && !no_prop));

  a_r6_cin_breaks_noprop: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !radix_bad && carry_in) |=> (!no_prop && !radix_err));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    a_r2_digit_below_radix: assert property (@(posedge clk) disable iff (!rst_q)
      (in_valid && !radix_bad
       && {1'b0, a_digits[k*DIGIT_W +: DIGIT_W]} < radix
       && {1'b0, b_digits[k*DIGIT_W +: DIGIT_W]} < radix)
      |=> ({1'b0, sum_digits[k*DIGIT_W +: DIGIT_W]} < $past(radix)));
  end

endmodule

// File: tb/test_radix_carry_unit.sv
module test_radix_carry_unit;
  localparam int LANES = 8;
  localparam int DW    = 8;
  localparam int VW    = LANES * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] a_digits = '0;
  logic [VW-1:0] b_digits = '0;
  logic [DW:0]   radix = '0;
  logic          carry_in = 1'b0;
  logic          out_valid;
  logic [VW-1:0] sum_digits;
  logic          carry_out;
  logic          no_prop;
  logic          radix_err;

  always #5 clk = ~clk;

  radix_carry_unit #(.LANES(LANES), .DIGIT_W(DW)) i_radix_carry_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_digits(a_digits), .b_digits(b_digits), .radix(radix), .carry_in(carry_in),
    .out_valid(out_valid), .sum_digits(sum_digits), .carry_out(carry_out),
    .no_prop(no_prop), .radix_err(radix_err)
  );

  typedef struct {
    logic [VW-1:0] digits;
    logic          cout;
    logic          noprop;
    logic          err;
    string         tag;
  } exp_t;

  exp_t queue_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   monitor_on = 0;
  bit   have_last  = 0;
  logic [VW-1:0] last_digits;
  logic last_cout, last_noprop, last_err;

  // Lane-by-lane ripple reference, written from the requirements.
  function automatic exp_t model(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                 input int r, input logic cin, input string tag);
    exp_t e;
    int   c;
    bit   any;
    e.tag = tag;
    e.digits = '0;
    if (r < 2 || r > (1 << DW)) begin
      e.cout = 0; e.noprop = 0; e.err = 1;
      return e;
    end
    c = int'(cin);
    any = 0;
    for (int i = 0; i < LANES; i++) begin
      int s;
      if (c != 0) any = 1;
      s = int'(a[i*DW +: DW]) + int'(b[i*DW +: DW]) + c;
      if (s >= r) begin s = s - r; c = 1; end
      else c = 0;
      e.digits[i*DW +: DW] = DW'(s);
    end
    e.cout = c[0]; e.noprop = !any; e.err = 0;
    return e;
  endfunction

  task automatic apply(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input int r, input logic cin, input string tag);
    @(negedge clk);
    a_digits = a; b_digits = b; radix = (DW+1)'(r); carry_in = cin; in_valid = 1'b1;
    queue_q.push_back(model(a, b, r, cin, tag));
  endtask

  task automatic idle_junk();
    @(negedge clk);
    in_valid = 1'b0;
    a_digits = {$urandom, $urandom}; b_digits = {$urandom, $urandom};
    radix = (DW+1)'($urandom); carry_in = 1'b1;
  endtask

  task automatic rand_vec(input int r, input logic cin, input string tag);
    logic [VW-1:0] a, b;
    for (int i = 0; i < LANES; i++) begin
      a[i*DW +: DW] = DW'($urandom % r);
      b[i*DW +: DW] = DW'($urandom % r);
    end
    apply(a, b, r, cin, tag);
  endtask

  function automatic logic [VW-1:0] fill(input int d);
    logic [VW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = DW'(d);
    return v;
  endfunction

  // Monitor: compares results with the scoreboard away from the clock edge.
  always @(negedge clk) begin
    if (monitor_on) begin
      if (out_valid) begin
        exp_t e;
        checks++;
        if (queue_q.size() == 0) begin
          fails++;
          $display("FAIL R1: result without pending input, got digits=%h expected none", sum_digits);
        end else begin
          e = queue_q.pop_front();
          if (sum_digits !== e.digits || carry_out !== e.cout ||
              no_prop !== e.noprop || radix_err !== e.err) begin
            fails++;
            $display("FAIL %s: got digits=%h cout=%b noprop=%b err=%b, expected digits=%h cout=%b noprop=%b err=%b",
                     e.tag, sum_digits, carry_out, no_prop, radix_err,
                     e.digits, e.cout, e.noprop, e.err);
          end
        end
        have_last = 1;
        last_digits = sum_digits; last_cout = carry_out;
        last_noprop = no_prop; last_err = radix_err;
      end else if (have_last) begin
        checks++;
        if (sum_digits !== last_digits || carry_out !== last_cout ||
            no_prop !== last_noprop || radix_err !== last_err) begin
          fails++;
          $display("FAIL R1 hold: got digits=%h cout=%b noprop=%b err=%b, expected digits=%h cout=%b noprop=%b err=%b",
                   sum_digits, carry_out, no_prop, radix_err,
                   last_digits, last_cout, last_noprop, last_err);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    logic [VW-1:0] a, b;
    // R9: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sum_digits !== '0 || carry_out !== 1'b0 ||
        no_prop !== 1'b0 || radix_err !== 1'b0) begin
      fails++;
      $display("FAIL R9: got valid=%b digits=%h cout=%b noprop=%b err=%b, expected all zero",
               out_valid, sum_digits, carry_out, no_prop, radix_err);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sum_digits !== '0 || radix_err !== 1'b0) begin
      fails++;
      $display("FAIL R9: after release got valid=%b digits=%h err=%b, expected 0 0 0",
               out_valid, sum_digits, radix_err);
    end
    monitor_on = 1;

    // R2, R3: random decimal vectors, both carry-in values
    for (int n = 0; n < 6; n++) rand_vec(10, n[0], "R2/R3 radix10");
    // R4: full chain, all lanes radix-1 with carry-in
    apply(fill(4), fill(5), 10, 1'b1, "R4 full chain");
    // R6: same operands without carry-in: nothing propagates
    apply(fill(4), fill(5), 10, 1'b0, "R6 no carry");
    // R6: non-carrying operands with carry-in into lane 0 only
    apply(fill(1), fill(2), 10, 1'b1, "R6 cin lane0");
    // R3: binary radix
    for (int n = 0; n < 4; n++) rand_vec(2, n[1], "R3 radix2");
    // R3, R5: single generate in lane 3, then in the top lane
    a = '0; b = '0; a[3*DW +: DW] = 8'd9; b[3*DW +: DW] = 8'd9;
    apply(a, b, 10, 1'b0, "R3 lane3 generate");
    a = '0; b = '0; a[7*DW +: DW] = 8'd9; b[7*DW +: DW] = 8'd5;
    apply(a, b, 10, 1'b0, "R5 top lane carry");
    // R8: full-width radix
    for (int n = 0; n < 3; n++) rand_vec(256, n[0], "R8 radix256");
    apply(fill(255), fill(0), 256, 1'b1, "R8 full chain 256");
    apply(fill(200), fill(100), 256, 1'b0, "R8 generate 256");
    // R2: odd radices
    rand_vec(3, 1'b1, "R2 radix3");
    rand_vec(255, 1'b0, "R2 radix255");
    // R7: unusable radices
    apply(fill(1), fill(1), 0, 1'b1, "R7 radix0");
    apply(fill(0), fill(0), 1, 1'b1, "R7 radix1");
    apply(fill(3), fill(4), 257, 1'b0, "R7 radix257");
    apply(fill(3), fill(4), 300, 1'b1, "R7 radix300");
    // R1: idle cycles with junk inputs must not disturb held results
    rand_vec(10, 1'b1, "R1 before idle");
    idle_junk(); idle_junk(); idle_junk();
    rand_vec(7, 1'b0, "R1 after idle");
    idle_junk(); idle_junk();
    @(negedge clk);
    #1;
    checks++;
    if (queue_q.size() != 0) begin
      fails++;
      $display("FAIL R1: got %0d results outstanding, expected 0", queue_q.size());
    end
    finish_run();
  end

endmodule